// File: doc/BRIEF.md
# Serial Audio Port Clock Router

This block supplies the bit clocks for a bank of serial audio ports. Four reference clocks arrive at its edge: three external references (A, B, C) and one internal reference. Two fractional-rate generators each take one of those references and divide it by six. One generator is meant for the 44.1 kHz sample-rate family and the other for the 48 kHz family. Each routed port then selects one of six clock sources through an 8-bit code. The selected clock passes through a gate whose enable is retimed on the falling edge of that same clock, so the gate opens and closes only while the clock is low.

Software programs the block through a simple word-wide write port and reads it back through a registered read port. The port codes are packed four to a 32-bit word: port n sits in byte (n mod 4) of select word (n div 4). The two generator source selections live in one byte, bits 23:16, of a control word at the address that follows the last select word. The last port has no route of its own and mirrors the clock of the port before it.

Top module: `audio_clk_router`

## Requirements
- R1: A routed port whose code is 0x01 outputs reference A, 0x02 outputs reference B, 0x03 outputs reference C, and 0x00 outputs the internal reference. Code 0x00 is the parked selection to which a port is returned when it is stopped.
- R2: A port whose code is 0x10 outputs the 44.1 kHz-family generator, and a port whose code is 0x20 outputs the 48 kHz-family generator.
- R3: Each generator's output has a period of exactly six cycles of its source and toggles once every three source rising edges.
- R4: In the control word, bits 23:20 choose the 44.1 kHz generator's source and bits 19:16 choose the 48 kHz generator's source. The source codes are 0x0 for A, 0x1 for B, 0x4 for C and 0x2 for the internal reference.
- R5: A port code other than the six listed in R1 and R2 holds that port's output low. A generator source code other than the four listed in R4 holds that generator's output low.
- R6: Select words are at addresses 0, 1 and 2, and port n's code is byte (n mod 4) of word (n div 4), at bits 8*(n mod 4)+7 down to 8*(n mod 4).
- R7: A write to the control word (address 3) changes only bits 23:16. Every other bit of that word reads back as zero whatever was written.
- R8: The last port (port 8) has no stored code: its byte (word 2, bits 7:0) and the bytes of non-existent ports read back zero. Its output always equals the output of port 7.
- R9: After reset every port code and the generator source byte are zero, so every port outputs the internal reference.
- R10: Read data appears on rd_data one clock after rd_addr is presented, and it shows the stored port codes and the generator source byte at the positions given in R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-side clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | 2 | Word address for writes (0-2 select words, 3 control word) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Word address for reads |
| rd_data | output | 32 | Registered read data |
| ext_a | input | 1 | External reference A |
| ext_b | input | 1 | External reference B |
| ext_c | input | 1 | External reference C |
| int_ref | input | 1 | Internal reference clock |
| port_clk | output | 9 | Gated bit clock for each serial audio port |

## Verification
The generator assertions assume that reset is held for several cycles of each reference, so that every divider counter starts from zero before the first checked edge. The register assertions assume that the write port is only driven away from the rising edge of clk. The bench meets both assumptions: it keeps all four references running throughout a twenty-cycle reset, and it changes every register input on the falling edge of clk. Before it counts edges it waits long enough after any reprogramming for each port's gate and each generator to settle on the new source. Only then does it open a fixed counting window.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

  // Port source codes (8-bit field per port)
  localparam logic [7:0] PCODE_INT  = 8'h00;
  localparam logic [7:0] PCODE_A    = 8'h01;
  localparam logic [7:0] PCODE_B    = 8'h02;
  localparam logic [7:0] PCODE_C    = 8'h03;
  localparam logic [7:0] PCODE_G44  = 8'h10;
  localparam logic [7:0] PCODE_G48  = 8'h20;

  // Generator source codes (4-bit field per generator)
  localparam logic [3:0] GCODE_A    = 4'h0;
  localparam logic [3:0] GCODE_B    = 4'h1;
  localparam logic [3:0] GCODE_INT  = 4'h2;
  localparam logic [3:0] GCODE_C    = 4'h4;

  // Generator source byte position inside the control word
  localparam int GSRC_LSB = 16;
  localparam int G44_HI   = 7;   // nibble [7:4] of the byte = word bits 23:20
  localparam int G48_HI   = 3;   // nibble [3:0] of the byte = word bits 19:16

  // Index of each clock on the shared source bus
  typedef enum logic [2:0] {
    SRC_INT = 3'd0,
    SRC_A   = 3'd1,
    SRC_B   = 3'd2,
    SRC_C   = 3'd3,
    SRC_G44 = 3'd4,
    SRC_G48 = 3'd5
  } src_idx_e;

  localparam int NUM_SRC = 6;

endpackage

// File: rtl/audio_clk_regs.sv
module audio_clk_regs
  import audio_clk_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  localparam int ROUTED    = NUM_PORTS - 1,
  localparam int SEL_WORDS = (NUM_PORTS + 3) / 4,
  localparam int CTRL_ADDR = SEL_WORDS,
  localparam int ADDR_W    = $clog2(SEL_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [31:0]             rd_data,
  output logic [ROUTED-1:0][7:0]  port_code,
  output logic [3:0]              g44_src,
  output logic [3:0]              g48_src
);

  localparam int BYP_WORD = (NUM_PORTS - 1) / 4;
  localparam int BYP_BYTE = (NUM_PORTS - 1) % 4;

  logic [ROUTED-1:0][7:0] code_q;
  logic [7:0]             gsrc_q;
  logic [31:0]            rd_word;
  logic                   ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  // One code register per routed port; the bypass port has none
  for (genvar p = 0; p < ROUTED; p++) begin : g_code
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q[p] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(p / 4))) begin
        code_q[p] <= wr_data[8*(p%4) +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gsrc_q <= '0;
    end else if (ctrl_wr) begin
      gsrc_q <= wr_data[GSRC_LSB +: 8];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < ROUTED; p++) begin
      if (rd_addr == ADDR_W'(p / 4)) begin
        rd_word[8*(p%4) +: 8] = code_q[p];
      end
    end
    if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_word[GSRC_LSB +: 8] = gsrc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_word;
    end
  end

  assign port_code = code_q;
  assign g44_src   = gsrc_q[G44_HI -: 4];
  assign g48_src   = gsrc_q[G48_HI -: 4];

  // R7
  ctrl_update_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (gsrc_q == $past(wr_data[GSRC_LSB +: 8])));

  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(gsrc_q));

  // R8
  bypass_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(BYP_WORD)) |=> (rd_data[8*BYP_BYTE +: 8] == 8'h00));

  // R10
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(CTRL_ADDR)) |=>
      ((rd_data[GSRC_LSB +: 8] == $past(gsrc_q)) && (rd_data[15:0] == 16'h0)));

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import audio_clk_pkg::*;
#(
  parameter int HALF_CYC = 3,
  localparam int CNT_W   = $clog2(HALF_CYC)
) (
  input  logic       rst,
  input  logic       ext_a,
  input  logic       ext_b,
  input  logic       ext_c,
  input  logic       int_ref,
  input  logic [3:0] src_code,
  output logic       gen_clk
);

  logic             src_clk;
  logic             src_ok;
  logic [CNT_W-1:0] cnt_q;
  logic             tog_q;

  always_comb begin
    src_ok  = 1'b1;
    src_clk = 1'b0;
    unique case (src_code)
      GCODE_A:   src_clk = ext_a;
      GCODE_B:   src_clk = ext_b;
      GCODE_C:   src_clk = ext_c;
      GCODE_INT: src_clk = int_ref;
      default:   src_ok  = 1'b0;
    endcase
  end

  // Toggle every HALF_CYC source edges: period = 2 * HALF_CYC source cycles
  always_ff @(posedge src_clk) begin
    if (rst) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (cnt_q == CNT_W'(HALF_CYC - 1)) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gen_clk = tog_q & src_ok;

  // R3
  gen_toggle_chk: assert property (@(posedge src_clk) disable iff (rst)
    (cnt_q == CNT_W'(HALF_CYC - 1)) |=> (tog_q != $past(tog_q)));

  // R3
  gen_hold_chk: assert property (@(posedge src_clk) disable iff (rst)
    (cnt_q != CNT_W'(HALF_CYC - 1)) |=> $stable(tog_q));

endmodule

// File: rtl/audio_clk_port.sv
module audio_clk_port
  import audio_clk_pkg::*;
(
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_bus,
  input  logic [7:0]         code,
  output logic               port_clk
);

  logic sel_clk;
  logic sel_ok;
  logic en_q;

  always_comb begin
    sel_ok  = 1'b1;
    sel_clk = 1'b0;
    unique case (code)
      PCODE_INT: sel_clk = src_bus[SRC_INT];
      PCODE_A:   sel_clk = src_bus[SRC_A];
      PCODE_B:   sel_clk = src_bus[SRC_B];
      PCODE_C:   sel_clk = src_bus[SRC_C];
      PCODE_G44: sel_clk = src_bus[SRC_G44];
      PCODE_G48: sel_clk = src_bus[SRC_G48];
      default:   sel_ok  = 1'b0;
    endcase
  end

  // Enable retimed while the selected clock is low
  always_ff @(negedge sel_clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else begin
      en_q <= sel_ok;
    end
  end

  assign port_clk = sel_clk & en_q;

endmodule

// File: rtl/audio_clk_router.sv
module audio_clk_router
  import audio_clk_pkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int GEN_HALF  = 3,
  localparam int ROUTED    = NUM_PORTS - 1,
  localparam int SEL_WORDS = (NUM_PORTS + 3) / 4,
  localparam int ADDR_W    = $clog2(SEL_WORDS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  input  logic                 ext_a,
  input  logic                 ext_b,
  input  logic                 ext_c,
  input  logic                 int_ref,
  output logic [NUM_PORTS-1:0] port_clk
);

  logic [ROUTED-1:0][7:0] port_code;
  logic [3:0]             g44_src;
  logic [3:0]             g48_src;
  logic [1:0][3:0]        gen_src;
  logic [1:0]             gen_clk;
  logic [NUM_SRC-1:0]     src_bus;

  audio_clk_regs #(.NUM_PORTS(NUM_PORTS)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .port_code (port_code),
    .g44_src   (g44_src),
    .g48_src   (g48_src)
  );

  assign gen_src[0] = g44_src;
  assign gen_src[1] = g48_src;

  for (genvar g = 0; g < 2; g++) begin : g_gen
    audio_clk_gen #(.HALF_CYC(GEN_HALF)) i_gen (
      .rst      (rst),
      .ext_a    (ext_a),
      .ext_b    (ext_b),
      .ext_c    (ext_c),
      .int_ref  (int_ref),
      .src_code (gen_src[g]),
      .gen_clk  (gen_clk[g])
    );
  end

  always_comb begin
    src_bus          = '0;
    src_bus[SRC_INT] = int_ref;
    src_bus[SRC_A]   = ext_a;
    src_bus[SRC_B]   = ext_b;
    src_bus[SRC_C]   = ext_c;
    src_bus[SRC_G44] = gen_clk[0];
    src_bus[SRC_G48] = gen_clk[1];
  end

  for (genvar p = 0; p < ROUTED; p++) begin : g_port
    audio_clk_port i_port (
      .rst      (rst),
      .src_bus  (src_bus),
      .code     (port_code[p]),
      .port_clk (port_clk[p])
    );
  end

  // Last port has no route of its own and follows its neighbour
  assign port_clk[NUM_PORTS-1] = port_clk[NUM_PORTS-2];

endmodule

// File: tb/test_audio_clk_router.sv
module test_audio_clk_router;

  localparam int CLK_NS  = 10;
  localparam int NP      = 9;
  localparam int WIN_NS  = 2520;
  localparam int SETTLE  = 400;
  localparam int PER_A   = 14;
  localparam int PER_B   = 18;
  localparam int PER_C   = 22;
  localparam int PER_I   = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ext_a = 1'b0;
  logic        ext_b = 1'b0;
  logic        ext_c = 1'b0;
  logic        int_ref = 1'b0;
  logic [NP-1:0] port_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] shadow [NP];
  logic [7:0] gsrc;
  int cnt [NP];
  int snap [NP];

  always #(CLK_NS/2) clk = ~clk;
  always #(PER_A/2) ext_a = ~ext_a;
  always #(PER_B/2) ext_b = ~ext_b;
  always #(PER_C/2) ext_c = ~ext_c;
  always #(PER_I/2) int_ref = ~int_ref;

  audio_clk_router i_audio_clk_router (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_a(ext_a), .ext_b(ext_b),
    .ext_c(ext_c), .int_ref(int_ref), .port_clk(port_clk)
  );

  for (genvar g = 0; g < NP; g++) begin : g_cnt
    initial cnt[g] = 0;
    always @(posedge port_clk[g]) cnt[g] = cnt[g] + 1;
  end

  function automatic int gen_period(input logic [3:0] s);
    case (s)
      4'h0: return 6 * PER_A;
      4'h1: return 6 * PER_B;
      4'h4: return 6 * PER_C;
      4'h2: return 6 * PER_I;
      default: return 0;
    endcase
  endfunction

  function automatic int port_period(input logic [7:0] c, input logic [7:0] gs);
    case (c)
      8'h00: return PER_I;
      8'h01: return PER_A;
      8'h02: return PER_B;
      8'h03: return PER_C;
      8'h10: return gen_period(gs[7:4]);
      8'h20: return gen_period(gs[3:0]);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      8'h00, 8'h01, 8'h02, 8'h03: return "R1";
      8'h10, 8'h20: return "R2/R3/R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_word(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: read %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // Program all select words and the control word from the shadow copy
  task automatic program_all(input logic [31:0] ctrl_word);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] d;
      d = $urandom;
      for (int b = 0; b < 4; b++) begin
        if (w * 4 + b < NP) d[8*b +: 8] = shadow[w*4+b];
      end
      wr(2'(w), d);
    end
    wr(2'd3, ctrl_word);
    gsrc = ctrl_word[23:16];
  endtask

  task automatic measure_ports(input string extra);
    #(SETTLE);
    for (int p = 0; p < NP; p++) snap[p] = cnt[p];
    #(WIN_NS);
    for (int p = 0; p < NP; p++) begin
      int got, per, lo, hi;
      logic [7:0] c;
      c = (p == NP - 1) ? shadow[NP-2] : shadow[p];
      got = cnt[p] - snap[p];
      per = port_period(c, gsrc);
      lo = (per == 0) ? 0 : WIN_NS / per - 1;
      hi = (per == 0) ? 0 : WIN_NS / per + 1;
      checks++;
      if (got < lo || got > hi) begin
        fails++;
        $display("FAIL %s%s%s: port %0d code %h edges %0d expected %0d..%0d",
                 tag_of(c), (p == NP - 1) ? "/R8" : "", extra, p, c, got, lo, hi);
      end
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] pcodes [8];
    logic [3:0] gcodes [5];
    pcodes = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h20, 8'h05, 8'hFF};
    gcodes = '{4'h0, 4'h1, 4'h4, 4'h2, 4'h7};
    void'($urandom(32'h00C1_0C4A));

    repeat (20) @(negedge clk);
    rst = 1'b0;

    // R9: reset state of every word and every port
    for (int w = 0; w < 4; w++) begin
      rd(2'(w), d);
      check_word("R9", d, 32'h0);
    end
    for (int p = 0; p < NP; p++) shadow[p] = 8'h00;
    gsrc = 8'h00;
    measure_ports("/R9");

    // R7: only bits 23:16 of the control word take the write
    wr(2'd3, 32'hDE1C_BEEF);
    rd(2'd3, d);
    check_word("R7", d, 32'h001C_0000);

    // R6/R10: byte packing readback of select words
    wr(2'd0, 32'h2010_0302);
    wr(2'd1, 32'h0100_FF05);
    rd(2'd0, d);
    check_word("R6/R10", d, 32'h2010_0302);
    rd(2'd1, d);
    check_word("R6/R10", d, 32'h0100_FF05);

    // R8: bypass byte and bytes of absent ports read zero
    wr(2'd2, 32'hA5A5_A520);
    rd(2'd2, d);
    check_word("R8", d, 32'h0);

    // R4/R5: generator source undefined holds generator low
    shadow = '{8'h10, 8'h20, 8'h01, 8'h02, 8'h03, 8'h00, 8'h10, 8'h20, 8'h77};
    program_all(32'h0072_0000);
    measure_ports("/R6");

    // Random vectors over all codes, including undefined ones
    for (int it = 0; it < 12; it++) begin
      logic [31:0] cw;
      for (int p = 0; p < NP; p++) shadow[p] = pcodes[$urandom % 8];
      cw = $urandom;
      cw[23:20] = gcodes[$urandom % 5];
      cw[19:16] = gcodes[$urandom % 5];
      program_all(cw);
      rd(2'd3, d);
      check_word("R7/R10", d, {8'h0, cw[23:16], 16'h0});
      measure_ports("/R6");
    end

    // R1: stop by returning all ports to the parked code
    for (int p = 0; p < NP; p++) shadow[p] = 8'h00;
    program_all(32'h0014_0000);
    measure_ports("/R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule